// File: doc/BRIEF.md
# Quasi-Bidirectional Pin Drive Controller

This block turns the contents of a parallel output latch into the per-pin drive controls of a row of quasi-bidirectional pins. There is no direction register. A pin that is latched low is pulled down hard. A pin that is latched high is held up only by a weak source, so an outside device can still pull it low and the pin can serve as an input. A pin written from low to high also gets a brief strong pull-up, which gives a fast rising edge into a heavy load. That strong pull-up ends at the next falling edge of the serial bus clock. The block also returns the synchronised pin levels for readback.

The serial core beside this block raises `latch_wr_i` for one clock when it commits a new byte on `latch_d_i`. It raises `scl_fall_i` for one clock on each falling edge of the bus clock.

Each pin has its own three-state machine:
- `DRV_LOW`: pull-down on, both pull-ups off.
- `DRV_BOOST`: weak and strong pull-ups on.
- `DRV_HOLD`: weak pull-up only.

The machine has these transitions:
- `LOW_TO_BOOST`: a write of 1 while in `DRV_LOW`.
- `BOOST_TO_HOLD`: a falling edge of the bus clock without a write of 0.
- `BOOST_TO_LOW` and `HOLD_TO_LOW`: a write of 0.
- A write of 1 while in `DRV_BOOST` or `DRV_HOLD` changes nothing, apart from the `BOOST_TO_HOLD` case above.

Reset places every pin in `DRV_HOLD`.

Top module: `qbp_drive_ctrl`

## Requirements
- R1: While reset is active, and right after it, `pull_dn_o` = 0, `strong_up_o` = 0, `weak_up_o` = all ones and `pin_rd_o` = all ones.
- R2: A write strobe with data bit n = 0 sets, from the next clock, `pull_dn_o[n]`=1, `weak_up_o[n]`=0 and `strong_up_o[n]`=0.
- R3: A write strobe with data bit n = 1 on a pin that is in `DRV_LOW` sets, from the next clock, `strong_up_o[n]`=1, `weak_up_o[n]`=1 and `pull_dn_o[n]`=0.
- R4: The strong pull-up stays on until a clock in which `scl_fall_i`=1. From the next clock it is off, and the weak pull-up stays on.
- R5: A write of 1 to a pin that is already high never starts a new strong pull-up.
- R6: If a write and `scl_fall_i` arrive in the same clock, the write decides for a pin leaving `DRV_LOW`, so the strong pull-up starts. A pin already boosting that is written 1 in that clock ends its strong pull-up.
- R7: Without a write strobe, changes on `latch_d_i` have no effect on any drive output.
- R8: Pull-down and weak pull-up are never on together on a pin, and the strong pull-up is never on without the weak pull-up.
- R9: `pin_rd_o` equals `pin_i` delayed by SYNC_STAGES clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| latch_wr_i | input | 1 | One-clock strobe that commits `latch_d_i` |
| latch_d_i | input | W | Output latch value |
| scl_fall_i | input | 1 | One-clock pulse on each falling edge of the bus clock |
| pin_i | input | W | Sensed pin levels |
| pull_dn_o | output | W | Strong pull-down enable per pin |
| weak_up_o | output | W | Weak pull-up enable per pin |
| strong_up_o | output | W | Momentary strong pull-up enable per pin |
| pin_rd_o | output | W | Synchronised pin levels for readback |

## Verification
The bench builds the block with W = 8 and SYNC_STAGES = 2. These values let it split one byte into pins that are low, pins that are rising and pins that stay high, all in a single write, so that each state transition happens side by side with the others. With two synchroniser stages the bench can observe the one-clock gap before a changed pin level reaches readback.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
    typedef enum logic [1:0] {
        DRV_LOW   = 2'd0,
        DRV_BOOST = 2'd1,
        DRV_HOLD  = 2'd2
    } drv_state_e;
endpackage

// File: rtl/qbp_bit_cell.sv
module qbp_bit_cell
    import qbp_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wr_i,
    input  logic d_i,
    input  logic scl_fall_i,
    output logic pull_dn_o,
    output logic weak_up_o,
    output logic strong_up_o
);
    drv_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= DRV_HOLD;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DRV_LOW: begin
                if (wr_i && d_i) state_d = DRV_BOOST;       // LOW_TO_BOOST
            end
            DRV_BOOST: begin
                if (wr_i && !d_i)    state_d = DRV_LOW;     // BOOST_TO_LOW
                else if (scl_fall_i) state_d = DRV_HOLD;    // BOOST_TO_HOLD
            end
            DRV_HOLD: begin
                if (wr_i && !d_i) state_d = DRV_LOW;        // HOLD_TO_LOW
            end
            default: state_d = DRV_HOLD;
        endcase
    end

    always_comb begin
        pull_dn_o   = 1'b0;
        weak_up_o   = 1'b0;
        strong_up_o = 1'b0;
        unique case (state_q)
            DRV_LOW:   pull_dn_o = 1'b1;
            DRV_BOOST: begin
                weak_up_o   = 1'b1;
                strong_up_o = 1'b1;
            end
            DRV_HOLD:  weak_up_o = 1'b1;
            default:   weak_up_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/qbp_pin_sync.sv
module qbp_pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pin_o
);
    generate
        if (STAGES == 0) begin : g_pass
            assign pin_o = pin_i;
        end else begin : g_chain
            logic [W-1:0] stage_q [STAGES];
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
                end else begin
                    stage_q[0] <= pin_i;
                    for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
                end
            end
            assign pin_o = stage_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/qbp_drive_ctrl.sv
module qbp_drive_ctrl #(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         latch_wr_i,
    input  logic [W-1:0] latch_d_i,
    input  logic         scl_fall_i,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pull_dn_o,
    output logic [W-1:0] weak_up_o,
    output logic [W-1:0] strong_up_o,
    output logic [W-1:0] pin_rd_o
);
    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            qbp_bit_cell u_cell (
                .clk_i      (clk_i),
                .rst_ni     (rst_ni),
                .wr_i       (latch_wr_i),
                .d_i        (latch_d_i[b]),
                .scl_fall_i (scl_fall_i),
                .pull_dn_o  (pull_dn_o[b]),
                .weak_up_o  (weak_up_o[b]),
                .strong_up_o(strong_up_o[b])
            );
        end
    endgenerate

    qbp_pin_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pin_i (pin_i),
        .pin_o (pin_rd_o)
    );
endmodule

// File: rtl/qbp_drive_ctrl_chk.sv
module qbp_drive_ctrl_chk #(
    parameter int W = 8
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         latch_wr_i,
    input logic [W-1:0] latch_d_i,
    input logic         scl_fall_i,
    input logic [W-1:0] pull_dn_o,
    input logic [W-1:0] weak_up_o,
    input logic [W-1:0] strong_up_o
);
    AST_NO_FIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pull_dn_o & weak_up_o) == '0); // R8
    AST_BOOST_NEEDS_WEAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strong_up_o & ~weak_up_o) == '0); // R8
    AST_LOW_FOLLOWS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        latch_wr_i |=> pull_dn_o == ~$past(latch_d_i)); // R2
    AST_RISE_BOOSTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        latch_wr_i |=> (strong_up_o & $past(latch_d_i & pull_dn_o)) == $past(latch_d_i & pull_dn_o)); // R3
    AST_FALL_CUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scl_fall_i && !latch_wr_i) |=> strong_up_o == '0); // R4
    AST_NO_NEW_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        latch_wr_i |=> (strong_up_o & ~$past(pull_dn_o) & ~$past(strong_up_o)) == '0); // R5
    AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !latch_wr_i |=> ($stable(pull_dn_o) && $stable(weak_up_o))); // R7
endmodule

bind qbp_drive_ctrl qbp_drive_ctrl_chk #(.W(W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .latch_wr_i (latch_wr_i),
    .latch_d_i  (latch_d_i),
    .scl_fall_i (scl_fall_i),
    .pull_dn_o  (pull_dn_o),
    .weak_up_o  (weak_up_o),
    .strong_up_o(strong_up_o)
);

// File: tb/sim_qbp_drive_ctrl.sv
module sim_qbp_drive_ctrl;
    localparam int W = 8;
    localparam int SYNC = 2;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr = 1'b0;
    logic [W-1:0] d = '0;
    logic         fall = 1'b0;
    logic [W-1:0] pin = '1;
    logic [W-1:0] pd, wk, st, rd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qbp_drive_ctrl #(.W(W), .SYNC_STAGES(SYNC)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .latch_wr_i(wr), .latch_d_i(d),
        .scl_fall_i(fall), .pin_i(pin), .pull_dn_o(pd), .weak_up_o(wk),
        .strong_up_o(st), .pin_rd_o(rd)
    );

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge: present inputs for one rising edge, return at the next falling edge.
    task automatic apply(input logic w, input logic [W-1:0] v, input logic f);
        wr = w; d = v; fall = f;
        @(negedge clk);
        wr = 1'b0; fall = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "pd in reset", pd, '0);
        chk("R1", "weak in reset", wk, '1);
        chk("R1", "strong in reset", st, '0);
        chk("R1", "readback in reset", rd, '1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "weak after reset", wk, '1);
        chk("R1", "strong after reset", st, '0);
    endtask

    task automatic t_write_low();
        apply(1'b1, 8'h0F, 1'b0);
        chk("R2", "pd after low write", pd, 8'hF0);
        chk("R2", "weak after low write", wk, 8'h0F);
        chk("R5", "no pulse on already-high bits", st, 8'h00);
    endtask

    task automatic t_rise_and_cut();
        apply(1'b1, 8'hFF, 1'b0);
        chk("R3", "strong on rising bits", st, 8'hF0);
        chk("R3", "weak on rising bits", wk, 8'hFF);
        chk("R3", "pd released", pd, 8'h00);
        apply(1'b0, 8'h00, 1'b0);
        chk("R4", "strong held without scl fall", st, 8'hF0);
        chk("R7", "pd ignores data without strobe", pd, 8'h00);
        apply(1'b0, 8'h00, 1'b1);
        chk("R4", "strong cut by scl fall", st, 8'h00);
        chk("R4", "weak kept after cut", wk, 8'hFF);
        apply(1'b1, 8'hFF, 1'b0);
        chk("R5", "rewrite high gives no pulse", st, 8'h00);
    endtask

    task automatic t_same_cycle();
        apply(1'b1, 8'h3C, 1'b0);
        chk("R2", "pd pattern 3C", pd, 8'hC3);
        apply(1'b1, 8'hFF, 1'b1);
        chk("R6", "write wins over scl fall", st, 8'hC3);
        apply(1'b1, 8'hFF, 1'b1);
        chk("R6", "boosting bit rewritten during fall ends", st, 8'h00);
        apply(1'b1, 8'hA5, 1'b0);
        chk("R2", "pd pattern A5", pd, 8'h5A);
        apply(1'b0, 8'hFF, 1'b0);
        chk("R7", "pd unchanged without strobe", pd, 8'h5A);
        chk("R7", "weak unchanged without strobe", wk, 8'hA5);
        chk("R7", "strong unchanged without strobe", st, 8'h00);
    endtask

    task automatic t_readback();
        pin = 8'hA5;
        @(negedge clk);
        chk("R9", "readback one clock after change", rd, 8'hFF);
        @(negedge clk);
        chk("R9", "readback after two clocks", rd, 8'hA5);
        pin = 8'h3C;
        repeat (2) @(negedge clk);
        chk("R9", "readback second pattern", rd, 8'h3C);
    endtask

    initial begin
        #(CLK_PERIOD * 10000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_write_low();
        t_rise_and_cut();
        t_same_cycle();
        t_readback();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule